// File: doc/BRIEF.md
# Two-Level Wavelet Packet Analysis Bank

This block splits a stream of signed 16-bit samples, for instance an electrocardiogram trace, into four subbands of equal width. A first stage filters the input with an 8-tap Daubechies-4 low-pass and high-pass pair and keeps every second result. A second stage then splits both of those streams again with the same pair, so the detail branch is divided as well as the approximation branch. Each of the four streams carries one coefficient for every four accepted input samples.

Samples enter with a one-cycle valid strobe, and the strobe may have gaps of any length. Each subband has its own valid strobe, a 16-bit coefficient and a fixed 2-bit subband index. All arithmetic is integer and bit exact. Each filter sums its full products in a wide accumulator and then rounds and saturates the sum back to 16 bits. Downstream logic such as coefficient shrinkage or reconstruction takes the four streams directly.

Top module: `wpd2_bank`

## Requirements
- R1: While reset is asserted and after it is released, every band valid bit is low and every coefficient output reads zero until the first coefficient is produced.
- R2: The low-pass taps in Q1.15 are h = {-347, 1078, 1011, -6129, -917, 20673, 23424, 7549} for k = 0..7. The high-pass taps are g[k] = (-1)^k * h[7-k].
- R3: Call the samples accepted since reset x[0], x[1], and so on. The first stage produces a[m] = Q(sum over k of h[k]*x[7+2m-k]) and d[m] = Q(sum over k of g[k]*x[7+2m-k]) for m >= 0. It keeps only the odd-indexed sample windows that are completely filled.
- R4: The second stage applies the same rule to a and d. Band 0 = Q(h applied to a), band 1 = Q(g applied to a), band 2 = Q(h applied to d), band 3 = Q(g applied to d), each evaluated at index 7+2j for coefficient j.
- R5: Q(s) adds 2^14 to the full-precision sum, shifts it right arithmetically by 15 and clamps the result to [-32768, 32767]. No overflow occurs before this step.
- R6: Coefficient j of every band appears exactly two clock cycles after the edge that accepts sample x[21+4j]. No coefficient appears at any other time.
- R7: The four band valid bits rise together and stay high for a single cycle.
- R8: Between valid pulses every coefficient output holds its last value.
- R9: A cycle with smp_vld low changes no state, whatever value smp_in carries.
- R10: band_idx carries value i in bits [2i+1:2i]: 0 low-low, 1 low-high, 2 high-low, 3 high-high. band_coef carries band i in bits [16i+15:16i].
- R11: A reset in mid-stream discards all pending work, and numbering restarts at x[0].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| smp_vld | input | 1 | Input sample strobe |
| smp_in | input | 16 | Signed input sample |
| band_vld | output | 4 | Per-band coefficient strobe |
| band_coef | output | 64 | Four signed 16-bit coefficients, band i at [16i+15:16i] |
| band_idx | output | 8 | Four 2-bit subband indices, band i at [2i+1:2i] |

## Verification
Four properties are checked on every clock cycle. The four band strobes must rise together for a single cycle. Each pulse must follow an accepted sample by exactly two cycles and fall on the sample count 21+4j. The coefficients must hold still between pulses. The coefficient values themselves can only be shown by the bench scenarios, which compare every output against an integer convolve-and-decimate model. These scenarios cover an impulse, a ramp, saturating constant and alternating inputs, random data with idle gaps, and a reset in mid-stream.

// File: rtl/wpd_pkg.sv
package wpd_pkg;
  localparam int SMP_W  = 16;
  localparam int COEF_W = 16;
  localparam int NTAP   = 8;
  localparam int FRAC   = 15;
  localparam int ACC_W  = SMP_W + COEF_W + $clog2(NTAP);
  localparam int SAT_HI = 2 ** (SMP_W - 1) - 1;
  localparam int SAT_LO = -SAT_HI - 1;

  // Daubechies-4 decomposition low-pass, Q1.15
  function automatic logic signed [COEF_W-1:0] lo_tap(input int k);
    case (k)
      0:       return COEF_W'(-347);
      1:       return COEF_W'(1078);
      2:       return COEF_W'(1011);
      3:       return COEF_W'(-6129);
      4:       return COEF_W'(-917);
      5:       return COEF_W'(20673);
      6:       return COEF_W'(23424);
      7:       return COEF_W'(7549);
      default: return '0;
    endcase
  endfunction

  // Quadrature mirror: g[k] = (-1)^k * h[N-1-k]
  function automatic logic signed [COEF_W-1:0] hi_tap(input int k);
    logic signed [COEF_W-1:0] t;
    t = lo_tap(NTAP - 1 - k);
    return (k % 2 == 0) ? t : -t;
  endfunction

  // Round half up, then clamp to the sample range
  function automatic logic signed [SMP_W-1:0] round_sat(input logic signed [ACC_W-1:0] acc);
    logic signed [ACC_W-1:0] r;
    r = (acc + (ACC_W'(1) <<< (FRAC - 1))) >>> FRAC;
    if (r > ACC_W'(SAT_HI))      return SMP_W'(SAT_HI);
    else if (r < ACC_W'(SAT_LO)) return SMP_W'(SAT_LO);
    else                         return SMP_W'(r);
  endfunction
endpackage

// File: rtl/wpd_dot.sv
module wpd_dot
  import wpd_pkg::*;
#(
  parameter int SW   = SMP_W,
  parameter int NT   = NTAP,
  parameter int AW   = ACC_W,
  parameter bit HIGH = 1'b0
) (
  input  logic signed [SW-1:0] win [NT],
  output logic signed [AW-1:0] acc
);
  logic signed [AW-1:0] prod [NT];

  for (genvar k = 0; k < NT; k++) begin : g_tap
    if (HIGH) begin : g_hp
      localparam logic signed [COEF_W-1:0] C = hi_tap(k);
      assign prod[k] = AW'(win[k]) * AW'(C);
    end else begin : g_lp
      localparam logic signed [COEF_W-1:0] C = lo_tap(k);
      assign prod[k] = AW'(win[k]) * AW'(C);
    end
  end

  always_comb begin
    acc = '0;
    for (int k = 0; k < NT; k++) acc = acc + prod[k];
  end
endmodule

// File: rtl/wpd_stage.sv
module wpd_stage
  import wpd_pkg::*;
#(
  parameter int SW = SMP_W,
  parameter int NT = NTAP,
  parameter int AW = ACC_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_vld,
  input  logic signed [SW-1:0] in_smp,
  output logic                 out_vld,
  output logic signed [SW-1:0] lo_out,
  output logic signed [SW-1:0] hi_out
);
  localparam int CNT_W = $clog2(NT);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(NT - 1);

  logic signed [SW-1:0] dl_q [NT-1];
  logic signed [SW-1:0] dl_d [NT-1];
  logic signed [SW-1:0] win  [NT];
  logic                 odd_q, odd_d;
  logic [CNT_W-1:0]     fill_q, fill_d;
  logic                 vld_q, vld_d;
  logic signed [SW-1:0] lo_q, lo_d, hi_q, hi_d;
  logic signed [AW-1:0] acc_lo, acc_hi;
  logic                 fire;

  always_comb begin
    win[0] = in_smp;
    for (int k = 1; k < NT; k++) win[k] = dl_q[k-1];
  end

  wpd_dot #(.SW(SW), .NT(NT), .AW(AW), .HIGH(1'b0)) dot_lo_i (.win(win), .acc(acc_lo));
  wpd_dot #(.SW(SW), .NT(NT), .AW(AW), .HIGH(1'b1)) dot_hi_i (.win(win), .acc(acc_hi));

  // fire on odd-indexed samples once the window holds only real samples
  assign fire = in_vld && odd_q && (fill_q == FULL);

  always_comb begin
    for (int k = 0; k < NT-1; k++) dl_d[k] = in_vld ? win[k] : dl_q[k];
    odd_d  = in_vld ? ~odd_q : odd_q;
    fill_d = (in_vld && fill_q != FULL) ? fill_q + 1'b1 : fill_q;
    vld_d  = fire;
    lo_d   = fire ? round_sat(acc_lo) : lo_q;
    hi_d   = fire ? round_sat(acc_hi) : hi_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NT-1; k++) dl_q[k] <= '0;
      odd_q  <= 1'b0;
      fill_q <= '0;
      vld_q  <= 1'b0;
      lo_q   <= '0;
      hi_q   <= '0;
    end else begin
      for (int k = 0; k < NT-1; k++) dl_q[k] <= dl_d[k];
      odd_q  <= odd_d;
      fill_q <= fill_d;
      vld_q  <= vld_d;
      lo_q   <= lo_d;
      hi_q   <= hi_d;
    end
  end

  assign out_vld = vld_q;
  assign lo_out  = lo_q;
  assign hi_out  = hi_q;
endmodule

// File: rtl/wpd2_bank.sv
module wpd2_bank
  import wpd_pkg::*;
#(
  parameter int SW = SMP_W,
  parameter int NT = NTAP,
  parameter int AW = ACC_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            smp_vld,
  input  logic [SW-1:0]   smp_in,
  output logic [3:0]      band_vld,
  output logic [4*SW-1:0] band_coef,
  output logic [7:0]      band_idx
);
  localparam int NBR   = 2;
  localparam int IDX_W = 2;

  logic                 l1_vld;
  logic signed [SW-1:0] l1_out [NBR];

  wpd_stage #(.SW(SW), .NT(NT), .AW(AW)) l1_i (
    .clk(clk), .rst_n(rst_n), .in_vld(smp_vld), .in_smp(smp_in),
    .out_vld(l1_vld), .lo_out(l1_out[0]), .hi_out(l1_out[1])
  );

  // branch b feeds bands 2b (low) and 2b+1 (high): natural tree order
  for (genvar b = 0; b < NBR; b++) begin : g_l2
    logic                 vld;
    logic signed [SW-1:0] lo, hi;
    wpd_stage #(.SW(SW), .NT(NT), .AW(AW)) st_i (
      .clk(clk), .rst_n(rst_n), .in_vld(l1_vld), .in_smp(l1_out[b]),
      .out_vld(vld), .lo_out(lo), .hi_out(hi)
    );
    assign band_vld[2*b]                    = vld;
    assign band_vld[2*b+1]                  = vld;
    assign band_coef[(2*b)*SW +: SW]        = lo;
    assign band_coef[(2*b+1)*SW +: SW]      = hi;
    assign band_idx[(2*b)*IDX_W +: IDX_W]   = IDX_W'(2*b);
    assign band_idx[(2*b+1)*IDX_W +: IDX_W] = IDX_W'(2*b+1);
  end
endmodule

// File: rtl/wpd2_bank_chk.sv
module wpd2_bank_chk #(
  parameter int SW = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            smp_vld,
  input logic [3:0]      band_vld,
  input logic [4*SW-1:0] band_coef
);
  logic [31:0] seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        seen_q <= '0;
    else if (smp_vld && seen_q != '1)  seen_q <= seen_q + 1'b1;
  end

  // R7: all four strobes move together
  assert_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (band_vld == 4'h0) || (band_vld == 4'hF));

  // R7: a strobe lasts one cycle
  assert_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|band_vld) |=> (band_vld == 4'h0));

  // R6: two cycles after an accepted sample
  assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|band_vld) |-> $past(smp_vld, 2));

  // R6: only on sample counts 22, 26, 30, ...
  assert_phase_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|band_vld) |-> ($past(seen_q) >= 32'd22 && $past(seen_q[1:0]) == 2'd2));

  // R8: outputs hold between strobes
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (band_vld == 4'h0) |-> $stable(band_coef));
endmodule

bind wpd2_bank wpd2_bank_chk #(.SW(SW)) chk_i (
  .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld),
  .band_vld(band_vld), .band_coef(band_coef)
);

// File: tb/wpd2_bank_tb_top.sv
`timescale 1ns/1ps
module wpd2_bank_tb_top;
  localparam int SW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          smp_vld = 1'b0;
  logic [SW-1:0] smp_in = '0;
  logic [3:0]    band_vld;
  logic [4*SW-1:0] band_coef;
  logic [7:0]    band_idx;

  always #5 clk = ~clk;

  wpd2_bank dut_i (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_in(smp_in),
    .band_vld(band_vld), .band_coef(band_coef), .band_idx(band_idx)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_vec = 0, n_bad = 0;
  int nacc, nextj, njobs;
  int xs [4096];
  int due [1024];
  int last [4];
  bit done = 0;

  // R2 taps, written from the requirement
  int H [8] = '{-347, 1078, 1011, -6129, -917, 20673, 23424, 7549};

  function automatic longint tap(int k, bit high);
    if (!high) return H[k];
    return (k % 2 == 0) ? H[7-k] : -H[7-k];
  endfunction

  // R5 rounding and clamp
  function automatic longint qz(longint s);
    longint r;
    r = (s + 16384) >>> 15;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  // R3 first stage
  function automatic longint lvl1(int m, bit high);
    longint s = 0;
    for (int k = 0; k < 8; k++) s += tap(k, high) * longint'(xs[7+2*m-k]);
    return qz(s);
  endfunction

  // R4 second stage, band b
  function automatic longint lvl2(int j, int b);
    longint s = 0;
    for (int k = 0; k < 8; k++) s += tap(k, b[0]) * lvl1(7+2*j-k, b[1]);
    return qz(s);
  endfunction

  task automatic chk(string tag, bit ok, longint act, longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic reset_model();
    nacc = 0; nextj = 0; njobs = 0;
    for (int b = 0; b < 4; b++) last[b] = 0;
  endtask

  task automatic check_out(string tag);
    bit exp_v;
    longint e, a;
    exp_v = (nextj < njobs) && (due[nextj] == cyc);
    chk("R10 index", band_idx == 8'hE4, band_idx, 8'hE4);
    if (exp_v) begin
      chk("R6 strobe", band_vld == 4'hF, band_vld, 4'hF);
      for (int b = 0; b < 4; b++) begin
        e = lvl2(nextj, b);
        a = $signed(band_coef[b*SW +: SW]);
        chk(tag, a == e, a, e);
        last[b] = int'(e);
      end
      nextj++;
    end else begin
      chk("R6 quiet", band_vld == 4'h0, band_vld, 0);
      for (int b = 0; b < 4; b++) begin
        a = $signed(band_coef[b*SW +: SW]);
        chk((nacc == 0) ? "R1 reset value" : "R8 hold", a == last[b], a, last[b]);
      end
    end
  endtask

  task automatic step(bit v, int s, string tag);
    @(negedge clk);
    check_out(tag);
    smp_vld = v;
    smp_in  = SW'(s);
    if (v) begin
      xs[nacc] = s;
      if (nacc >= 21 && (nacc - 21) % 4 == 0) begin
        due[njobs] = cyc + 2;
        njobs++;
      end
      nacc++;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; smp_vld = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 reset strobe", band_vld == 4'h0, band_vld, 0);
    chk("R1 reset data", band_coef == '0, 0, 0);
    rst_n = 1'b1;
    reset_model();
  endtask

  function automatic int rnd16();
    return int'($urandom_range(0, 65535)) - 32768;
  endfunction

  initial begin
    reset_model();
    do_reset();
    for (int i = 0; i < 4; i++) step(0, 12345, "R1");
    // R2: impulse exposes the taps
    for (int i = 0; i < 120; i++) step(1, (i == 12) ? 20000 : 0, "R2 impulse");
    // R3: ramp
    for (int i = 0; i < 100; i++) step(1, i * 200 - 12000, "R3 ramp");
    // R5: saturating constants and alternation
    for (int i = 0; i < 60; i++) step(1, 32767, "R5 dc high");
    for (int i = 0; i < 60; i++) step(1, -32768, "R5 dc low");
    for (int i = 0; i < 60; i++) step(1, (i % 2) ? -32768 : 32767, "R5 alternating");
    for (int i = 0; i < 60; i++) step(1, ((i / 2) % 2) ? -32768 : 32767, "R5 pairs");
    // R9: random data with idle gaps carrying garbage
    for (int i = 0; i < 600; i++) step(($urandom_range(0, 2) != 0), rnd16(), "R9 gaps");
    // R11: reset mid-stream then restart
    for (int i = 0; i < 23; i++) step(1, rnd16(), "R11 before");
    do_reset();
    for (int i = 0; i < 120; i++) step(1, rnd16(), "R11 restart");
    for (int i = 0; i < 300; i++) step(1, rnd16(), "R4 random");
    for (int i = 0; i < 6; i++) step(0, 0, "R8 drain");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R6 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule